// File: doc/BRIEF.md
# Multiplier-free adaptive FIR filter with grouped partial-product memories

This block is an adaptive FIR filter that has no multiplier. It holds no tap coefficients. Its state is a set of small partial-product memories. The N taps are split into M groups of R neighbouring taps. Each group owns a register-file memory of 2^R words. That memory is addressed by one bit-slice of the group's delayed input samples, and each word holds the sum of the group's coefficients for the taps whose bit is set.

Each input sample is processed bit-serially over B cycles. The bit-slices run from least to most significant. In each cycle the M memory outputs are summed and folded into a shift-accumulator. The sign-bit slice is subtracted, so the result is the usual two's-complement inner product.

The error is the desired sample minus the output. The step size is a power of two, so the error is scaled by arithmetic shifts alone. A second pass of B cycles then revisits every word that was addressed and adds the scaled error to it, weighted like the output term it contributed. The result is an LMS update applied directly to the stored partial products.

Top module: `dalms_filter`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears every memory word, every delay-line entry, `y_o` and `e_o` to zero and holds `out_vld_o` low. The first sample after reset therefore gives `y_o` = 0 and `e_o` = `d_i`.
- R2: A strobe that is accepted (`in_vld_i` high while idle) shifts the delay line once, before that sample's bit cycles. Entry 0 takes the new `s_i` and entry i takes the old entry i-1. Group g uses entries g·R to g·R+R-1. Address bit j of group g at bit position k is bit k of entry g·R+j.
- R3: With S_k the sum of the M group words addressed at bit position k (k = 0 is the LSB, B-1 the sign bit), the accumulator starts at 0 and becomes floor((acc + S_k)/2) for k = 0..B-2. The output is then acc - S_{B-1}, clipped to the signed WW-bit range.
- R4: `e_o` equals `d_i` (as latched with the accepted strobe) minus the new `y_o`, clipped to the signed WW-bit range.
- R5: In the update pass, for k = 0..B-1 in that order, each group's word at its bit-k address gets the increment added and is clipped to the signed WW-bit range. The increment is e >>> (MU_SH + B-1-k) for k < B-1, and -(e >>> MU_SH) for k = B-1 (arithmetic shifts). A word addressed at several positions is updated once per position.
- R6: `y_o` and `e_o` change only in the cycle where `out_vld_o` is high. That one-cycle pulse comes B+1 falling edges after the strobe is driven, so the result is ready B cycles after the accepting edge.
- R7: After accepting a strobe the block is busy for 2B cycles. A strobe during that window is ignored and leaves no trace in later results.
- R8: With a fixed small FIR target driven by a random input, the mean error magnitude over the last 32 samples is under a quarter of that over the first 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_vld_i | input | 1 | Sample strobe |
| s_i | input | SW | Input sample, two's-complement fraction |
| d_i | input | WW | Desired sample, same scale as the output |
| y_o | output | WW | Filter output |
| e_o | output | WW | Error d - y |
| out_vld_o | output | 1 | One-cycle pulse when y_o and e_o are updated |

## Verification
The assertions assume the strobe is a clean synchronous level. They also assume a strobe seen while busy never starts a second sample, so the latency counter in the checker only restarts on accepted strobes. The bench drives each sample on a falling edge, then waits for the result pulse and for the rest of the update pass before driving the next one. The one deliberate break of that spacing is the ignored-strobe test. There the bench checks that results still track a reference model that drops the extra strobe.

// File: rtl/dalms_pkg.sv
package dalms_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CALC,
        PH_UPD
    } phase_e;

    // clip a signed value to a signed w-bit range
    function automatic logic signed [31:0] clip_s(input logic signed [31:0] v, input int w);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (w - 1)) - 32'sd1;
        lo = -(32'sd1 <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/dalms_pp_bank.sv
module dalms_pp_bank
    import dalms_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] delta_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0]        mem_q [DEPTH];
    logic [WORD_W-1:0]        mem_d [DEPTH];
    logic signed [31:0]       sum_w;

    always_comb begin
        mem_d = mem_q;
        sum_w = 32'($signed(mem_q[addr_i])) + 32'($signed(delta_i));
        if (wr_en_i) begin
            mem_d[addr_i] = WORD_W'(clip_s(sum_w, WORD_W));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) mem_q <= '{default: '0};
        else       mem_q <= mem_d;
    end

    assign word_o = mem_q[addr_i];

endmodule

// File: rtl/dalms_bank_sum.sv
module dalms_bank_sum #(
    parameter int NGRP   = 4,
    parameter int WORD_W = 16,
    parameter int SUM_W  = WORD_W + $clog2(NGRP)
) (
    input  logic [NGRP*WORD_W-1:0] words_i,
    output logic [SUM_W-1:0]       sum_o
);
    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int g = 0; g < NGRP; g++) begin
            acc = acc + SUM_W'($signed(words_i[g*WORD_W +: WORD_W]));
        end
        sum_o = acc;
    end

endmodule

// File: rtl/dalms_filter.sv
module dalms_filter
    import dalms_pkg::*;
#(
    parameter int NTAP  = 8,
    parameter int GRP_W = 2,
    parameter int SW    = 12,
    parameter int WW    = 16,
    parameter int MU_SH = 4
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          in_vld_i,
    input  logic [SW-1:0] s_i,
    input  logic [WW-1:0] d_i,
    output logic [WW-1:0] y_o,
    output logic [WW-1:0] e_o,
    output logic          out_vld_o
);
    localparam int NGRP  = NTAP / GRP_W;
    localparam int SUM_W = WW + $clog2(NGRP);
    localparam int AW    = SUM_W + 2;
    localparam int CNT_W = $clog2(SW);

    typedef struct packed {
        phase_e                   phase;
        logic [CNT_W-1:0]         pos;
        logic [NTAP-1:0][SW-1:0]  taps;
        logic [WW-1:0]            dref;
        logic [AW-1:0]            acc;
        logic [WW-1:0]            y;
        logic [WW-1:0]            e;
        logic                     vld;
    } state_t;

    state_t st_q, st_d;

    logic [NGRP*WW-1:0] words;
    logic [SUM_W-1:0]   bank_sum;
    logic [WW-1:0]      delta;
    logic               upd_en;
    logic               busy;

    // one memory bank per tap group
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GRP_W-1:0] addr_g;
        always_comb begin
            for (int j = 0; j < GRP_W; j++) begin
                addr_g[j] = st_q.taps[g*GRP_W + j][st_q.pos];
            end
        end
        dalms_pp_bank #(.ADDR_W(GRP_W), .WORD_W(WW)) u_bank (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .addr_i  (addr_g),
            .wr_en_i (upd_en),
            .delta_i (delta),
            .word_o  (words[g*WW +: WW])
        );
    end

    dalms_bank_sum #(.NGRP(NGRP), .WORD_W(WW), .SUM_W(SUM_W)) u_sum (
        .words_i (words),
        .sum_o   (bank_sum)
    );

    logic signed [AW-1:0] sum_ext, acc_add, y_full;
    logic signed [31:0]   y_clip, e_clip, delta32;
    int                   shamt;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        sum_ext  = AW'($signed(bank_sum));
        acc_add  = $signed(st_q.acc) + sum_ext;
        y_full   = $signed(st_q.acc) - sum_ext;
        y_clip   = clip_s(32'(y_full), WW);
        e_clip   = clip_s(32'($signed(st_q.dref)) - y_clip, WW);
        shamt    = MU_SH + SW - 1 - int'(st_q.pos);
        if (int'(st_q.pos) == SW - 1) delta32 = -(32'($signed(st_q.e)) >>> MU_SH);
        else                          delta32 = 32'($signed(st_q.e)) >>> shamt;
        delta    = WW'(delta32);
        upd_en   = (st_q.phase == PH_UPD);

        case (st_q.phase)
            PH_IDLE: begin
                if (in_vld_i) begin
                    st_d.taps  = {st_q.taps[NTAP-2:0], s_i};
                    st_d.dref  = d_i;
                    st_d.acc   = '0;
                    st_d.pos   = '0;
                    st_d.phase = PH_CALC;
                end
            end
            PH_CALC: begin
                if (int'(st_q.pos) == SW - 1) begin
                    st_d.y     = WW'(y_clip);
                    st_d.e     = WW'(e_clip);
                    st_d.vld   = 1'b1;
                    st_d.pos   = '0;
                    st_d.phase = PH_UPD;
                end else begin
                    st_d.acc = acc_add >>> 1;
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
            PH_UPD: begin
                if (int'(st_q.pos) == SW - 1) begin
                    st_d.pos   = '0;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign y_o       = st_q.y;
    assign e_o       = st_q.e;
    assign out_vld_o = st_q.vld;

endmodule

// File: rtl/dalms_filter_chk.sv
module dalms_filter_chk #(
    parameter int SW = 12,
    parameter int WW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic          busy,
    input logic          out_vld,
    input logic [WW-1:0] y,
    input logic [WW-1:0] e
);
    localparam int LIM = 2 * SW + 4;

    int unsigned since_q;

    always_ff @(posedge clk) begin
        if (rst)                              since_q <= 0;
        else if (in_vld && !busy)             since_q <= 1;
        else if (since_q != 0 && since_q < LIM) since_q <= since_q + 1;
        else                                  since_q <= 0;
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> !out_vld);                                        // R6
    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> since_q == unsigned'(SW + 1));                    // R6
    AST_Y_ONLY_ON_VLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(y) |-> out_vld);                                     // R6
    AST_E_ONLY_ON_VLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(e) |-> out_vld);                                     // R4
    AST_TAKE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !busy) |=> busy);                                  // R7
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> since_q == unsigned'(2 * SW + 1));            // R7

endmodule

bind dalms_filter dalms_filter_chk #(.SW(SW), .WW(WW)) u_chk (
    .clk     (clk_i),
    .rst     (rst_i),
    .in_vld  (in_vld_i),
    .busy    (busy),
    .out_vld (out_vld_o),
    .y       (y_o),
    .e       (e_o)
);

// File: tb/dalms_filter_bench.sv
module dalms_filter_bench;
    localparam int NT = 8;
    localparam int RG = 2;
    localparam int NG = NT / RG;
    localparam int SB = 12;
    localparam int WB = 16;
    localparam int MU = 4;
    localparam int NVEC = 8;
    localparam int VEC [NVEC][2] = '{
        '{  700,   300}, '{-1500,  -800}, '{ 2047, 32767}, '{-2048, -32768},
        '{    1,     5}, '{ -333,  1200}, '{ 1024,  -600}, '{    0,   250}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [SB-1:0] s_in = '0;
    logic [WB-1:0] d_in = '0;
    logic [WB-1:0] y_out, e_out;
    logic          out_vld;

    int n_chk = 0;
    int n_fail = 0;
    int mem [NG][1 << RG];
    int taps [NT];
    int lcg = 12345;

    always #2 clk = ~clk;

    dalms_filter u_dalms_filter (
        .clk_i (clk), .rst_i (rst), .in_vld_i (in_vld), .s_i (s_in), .d_i (d_in),
        .y_o (y_out), .e_o (e_out), .out_vld_o (out_vld)
    );

    function automatic int clip16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int g = 0; g < NG; g++)
            for (int a = 0; a < (1 << RG); a++) mem[g][a] = 0;
        for (int i = 0; i < NT; i++) taps[i] = 0;
    endtask

    function automatic int addr_of(int g, int k);
        int a = 0;
        for (int j = 0; j < RG; j++) a |= ((taps[g*RG + j] >>> k) & 1) << j;
        return a;
    endfunction

    // reference of R2..R5
    task automatic model_step(input int s, input int d, output int ym, output int em);
        int acc = 0;
        int yf = 0;
        int sum;
        int dl;
        for (int i = NT - 1; i > 0; i--) taps[i] = taps[i-1];
        taps[0] = s;
        for (int k = 0; k < SB; k++) begin
            sum = 0;
            for (int g = 0; g < NG; g++) sum += mem[g][addr_of(g, k)];
            if (k < SB - 1) acc = (acc + sum) >>> 1;
            else            yf = acc - sum;
        end
        ym = clip16(yf);
        em = clip16(d - ym);
        for (int k = 0; k < SB; k++) begin
            dl = (k < SB - 1) ? (em >>> (MU + SB - 1 - k)) : -(em >>> MU);
            for (int g = 0; g < NG; g++) begin
                int a = addr_of(g, k);
                mem[g][a] = clip16(mem[g][a] + dl);
            end
        end
    endtask

    task automatic run_sample(input int s, input int d, input bit poke,
                              output int yo, output int eo, output int lat);
        @(negedge clk);
        in_vld = 1'b1; s_in = SB'(s); d_in = WB'(d);
        @(negedge clk);
        in_vld = 1'b0;
        lat = 1;
        while (!out_vld && lat < 60) begin
            @(negedge clk);
            if (poke && lat == 3) begin
                in_vld = 1'b1; s_in = 12'h555; d_in = 16'd1234;
            end else begin
                in_vld = 1'b0;
            end
            lat++;
        end
        in_vld = 1'b0;
        yo = int'($signed(y_out));
        eo = int'($signed(e_out));
        repeat (SB + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int ym, em, yo, eo, lat;
        int first_sum, last_sum, x0, x1, x2, x5, xs, dt;
        int hist [NT];

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 y after reset", int'($signed(y_out)), 0);
        check("R1 e after reset", int'($signed(e_out)), 0);
        check("R1 out_vld after reset", int'(out_vld), 0);
        model_clear();

        // table walk: R2/R3/R4/R5 via reference, R6 latency
        for (int v = 0; v < NVEC; v++) begin
            model_step(VEC[v][0], VEC[v][1], ym, em);
            run_sample(VEC[v][0], VEC[v][1], 1'b0, yo, eo, lat);
            if (v == 0) check("R1 first e equals d", eo, VEC[v][1]);
            check("R3 y vs model", yo, ym);
            check("R4 e vs model", eo, em);
            check("R6 latency", lat, SB + 1);
        end

        // R7: a strobe during the busy window is dropped
        model_step(400, -900, ym, em);
        run_sample(400, -900, 1'b1, yo, eo, lat);
        check("R7 y with mid-pass strobe", yo, ym);
        check("R7 e with mid-pass strobe", eo, em);
        model_step(-50, 60, ym, em);
        run_sample(-50, 60, 1'b0, yo, eo, lat);
        check("R7 next y unaffected", yo, ym);
        check("R7 next e unaffected", eo, em);

        // R5 repeated training drives y to the top, R4 error clip
        for (int i = 0; i < 24; i++) begin
            model_step(-2048, 32767, ym, em);
            run_sample(-2048, 32767, 1'b0, yo, eo, lat);
            check("R5 training y vs model", yo, ym);
        end
        model_step(-2048, -32768, ym, em);
        run_sample(-2048, -32768, 1'b0, yo, eo, lat);
        check("R4 error clipped low", eo, -32768);
        check("R4 clipped error vs model", eo, em);

        // R1 reset clears memories
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        model_clear();
        for (int i = 0; i < NT; i++) hist[i] = 0;

        // R8 identification of a fixed FIR target
        first_sum = 0; last_sum = 0;
        for (int n = 0; n < 200; n++) begin
            lcg = lcg * 1103515245 + 12345;
            xs = ((lcg >>> 8) % 4095);
            if (xs < 0) xs = -xs;
            xs = xs - 2047;
            for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = xs;
            x0 = hist[0]; x1 = hist[1]; x2 = hist[2]; x5 = hist[5];
            dt = (4096 * x0 - 2048 * x1 + 1024 * x2 + 512 * x5) >>> 11;
            model_step(xs, dt, ym, em);
            run_sample(xs, dt, 1'b0, yo, eo, lat);
            if (n == 0) check("R1 memories cleared, y", yo, 0);
            if (eo != em) check("R8 e vs model", eo, em);
            if (n < 32)   first_sum += (eo < 0) ? -eo : eo;
            if (n >= 168) last_sum  += (eo < 0) ? -eo : eo;
        end
        check("R8 error shrinks", int'(last_sum * 4 < first_sum), 1);
        finish_run();
    end

endmodule